// File: doc/BRIEF.md
# Inverting Two-Level Binary Image Shrinker

This block shrinks a bilevel page image by a factor of four along each axis. On the way in, it turns dark-on-light ink into a set-bit foreground. The image arrives already cut into tiles. Each 64-bit input word holds four image rows by sixteen image columns. Words come tile-row by tile-row, and left to right within a tile-row.

Every incoming pixel is complemented first, so ink (0) becomes 1 and paper (1) becomes 0. Two 2x2 reductions with a threshold of one then run in cascade. A reduced pixel is set when any of the four pixels under it is set. The first level turns the 64 pixels of a tile into a 2x8 patch. The second level turns that patch into a 1x4 strip. So each tile yields one group of four output pixels.

A tile-row of input covers exactly one output row, so the groups leave in raster order without any line storage. Each group carries a flag that marks the first group of an output row and a flag that marks the last group of the frame. Both streams use valid/ready handshakes. A single output register holds a group while the consumer stalls.

Top module: `bin_quad_shrink`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A word of all ones (pure paper) produces a group of 0000. A word of all zeros (pure ink) produces 1111.
- R3: Input bit `r*16+c` is the pixel at tile row `r` (0..3) and tile column `c` (0..15), with bit 0 at the top-left. A zero at that bit sets output bit `c/4` and no other output bit.
- R4: Output bit `k` is 1 exactly when at least one of the 16 input bits at rows 0..3 and columns `4k..4k+3` is 0.
- R5: Output bit 0 is the leftmost pixel of the group. Each accepted word yields exactly one group, and groups leave in the order their words were accepted.
- R6: A word accepted on a clock edge appears at the output after that same edge. `out_valid` is high exactly while an accepted group has not yet been taken.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output group and flags hold steady.
- R8: `out_sor` is 1 on the first group of every output row, which is every `IMG_W/16`-th group starting with the first.
- R9: `out_eof` is 1 only on the last group of each frame (group `IMG_W*IMG_H/64`). The position then wraps, so the next group starts a new frame with `out_sor` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input tile word is offered |
| in_ready | output | 1 | The block takes the offered word on this edge |
| in_word | input | 64 | 4x16 tile, bit `r*16+c`, where 0 is ink |
| out_valid | output | 1 | A reduced group is offered |
| out_ready | input | 1 | The consumer takes the group on this edge |
| out_pix | output | 4 | Reduced pixels, bit 0 leftmost, where 1 is foreground |
| out_sor | output | 1 | The group is the first in its output row |
| out_eof | output | 1 | The group is the last in the frame |

## Verification
Uniform paper and uniform ink words pin down the inversion and the two output extremes. A single ink pixel walked across all 64 bit positions exposes any swapped row, column or group in the bit layout. Random words check the any-one-of-sixteen rule against blocks with many mixed counts. Words whose ink sits in a group that rotates from word to word make any reordering or duplication visible. A randomly stalling consumer over several frames tests holding under back-pressure, the row-start and frame-end flags, and the wrap between frames.

// File: rtl/bqs_pkg.sv
`timescale 1ns/1ps
package bqs_pkg;
   localparam int TILE_ROWS = 4;
   localparam int TILE_COLS = 16;
   localparam int WORD_W    = TILE_ROWS * TILE_COLS;
   localparam int SHRINK    = 4;
   localparam int OUT_PIX   = (TILE_ROWS / SHRINK) * (TILE_COLS / SHRINK);
endpackage

// File: rtl/bqs_level.sv
`timescale 1ns/1ps
module bqs_level #(
   parameter int ROWS = 4,
   parameter int COLS = 16
) (
   input  logic [ROWS*COLS-1:0]         din,
   output logic [(ROWS/2)*(COLS/2)-1:0] dout
);
   localparam int OR_ = ROWS / 2;
   localparam int OC  = COLS / 2;

   if ((ROWS % 2) != 0 || (COLS % 2) != 0 || ROWS < 2) begin : g_bad_dims
      $error("bqs_level: ROWS and COLS must be even and nonzero");
   end

   for (genvar r = 0; r < OR_; r++) begin : g_row
      for (genvar c = 0; c < OC; c++) begin : g_col
         assign dout[r*OC + c] = din[(2*r)*COLS + 2*c]   | din[(2*r)*COLS + 2*c + 1]
                               | din[(2*r+1)*COLS + 2*c] | din[(2*r+1)*COLS + 2*c + 1];
      end
   end
endmodule

// File: rtl/bqs_position.sv
`timescale 1ns/1ps
module bqs_position #(
   parameter int WPR   = 4,
   parameter int TROWS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic first_col,
   output logic last_word
);
   localparam int CW = (WPR   > 1) ? $clog2(WPR)   : 1;
   localparam int RW = (TROWS > 1) ? $clog2(TROWS) : 1;
   localparam logic [CW-1:0] COL_LAST = CW'(WPR - 1);
   localparam logic [RW-1:0] ROW_LAST = RW'(TROWS - 1);

   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;
   logic          col_end;

   assign col_end   = (col_q == COL_LAST);
   assign first_col = (col_q == '0);
   assign last_word = col_end && (row_q == ROW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (adv) begin
         col_q <= col_end ? '0 : col_q + 1'b1;
         if (col_end) row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end
   end

   p_frame_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      adv && last_word |=> first_col && (row_q == '0));
   p_col_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= COL_LAST);
endmodule

// File: rtl/bqs_stage.sv
`timescale 1ns/1ps
module bqs_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_pix,
   input  logic         in_sor,
   input  logic         in_eof,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_pix,
   output logic         out_sor,
   output logic         out_eof
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
         out_sor   <= 1'b0;
         out_eof   <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_pix <= in_pix;
            out_sor <= in_sor;
            out_eof <= in_eof;
         end
      end
   end

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sor) && $stable(out_eof));
endmodule

// File: rtl/bin_quad_shrink.sv
`timescale 1ns/1ps
module bin_quad_shrink
   import bqs_pkg::*;
#(
   parameter int IMG_W = 64,
   parameter int IMG_H = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_PIX-1:0] out_pix,
   output logic              out_sor,
   output logic              out_eof
);
   localparam int WPR   = IMG_W / TILE_COLS;
   localparam int TROWS = IMG_H / TILE_ROWS;
   localparam int MID_W = (TILE_ROWS / 2) * (TILE_COLS / 2);

   if ((IMG_W % TILE_COLS) != 0 || IMG_W < TILE_COLS) begin : g_bad_w
      $error("bin_quad_shrink: IMG_W must be a nonzero multiple of 16");
   end
   if ((IMG_H % TILE_ROWS) != 0 || IMG_H < TILE_ROWS) begin : g_bad_h
      $error("bin_quad_shrink: IMG_H must be a nonzero multiple of 4");
   end

   logic [WORD_W-1:0]  fg;
   logic [MID_W-1:0]   half;
   logic [OUT_PIX-1:0] quarter;
   logic               take, first_col, last_word;

   assign fg   = ~in_word;
   assign take = in_valid && in_ready;

   bqs_level #(.ROWS(TILE_ROWS), .COLS(TILE_COLS)) u_lvl1 (
      .din (fg),
      .dout(half)
   );

   bqs_level #(.ROWS(TILE_ROWS/2), .COLS(TILE_COLS/2)) u_lvl2 (
      .din (half),
      .dout(quarter)
   );

   bqs_position #(.WPR(WPR), .TROWS(TROWS)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (take),
      .first_col(first_col),
      .last_word(last_word)
   );

   bqs_stage #(.W(OUT_PIX)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_pix   (quarter),
      .in_sor   (first_col),
      .in_eof   (last_word),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_pix  (out_pix),
      .out_sor  (out_sor),
      .out_eof  (out_eof)
   );

   p_accept_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
   p_paper_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (&in_word) |=> out_pix == '0);
   p_ink_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (in_word == '0) |=> (&out_pix));
endmodule

// File: tb/bin_quad_shrink_test.sv
`timescale 1ns/1ps
module bin_quad_shrink_test;
   localparam int IMG_W = 64;
   localparam int IMG_H = 16;
   localparam int WPR   = IMG_W / 16;
   localparam int TR    = IMG_H / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [3:0]  out_pix;
   logic        out_sor, out_eof;

   int checks = 0;
   int fails  = 0;
   int mcol = 0, mrow = 0;
   bit bp = 0;
   bit stall_prev = 0;
   logic [5:0] held;

   logic [3:0] q_pix[$];
   logic       q_sor[$];
   logic       q_eof[$];
   string      q_tag[$];

   always #2.5 clk = ~clk;

   bin_quad_shrink #(.IMG_W(IMG_W), .IMG_H(IMG_H)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_pix(out_pix), .out_sor(out_sor), .out_eof(out_eof)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_group(input logic [63:0] w);
      logic [3:0] g = '0;
      for (int k = 0; k < 4; k++)
         for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
               if (w[r*16 + 4*k + c] == 1'b0) g[k] = 1'b1;
      return g;
   endfunction

   task automatic compare();
      check("R6", {7'd0, out_valid}, {7'd0, q_pix.size() != 0}, "out_valid");
      if (stall_prev)
         check("R7", {2'd0, out_pix, out_sor, out_eof}, {2'd0, held}, "hold under stall");
      if (out_valid && q_pix.size() != 0) begin
         check(q_tag[0], {4'd0, out_pix}, {4'd0, q_pix[0]}, "group");
         check("R8", {7'd0, out_sor}, {7'd0, q_sor[0]}, "row start");
         check("R9", {7'd0, out_eof}, {7'd0, q_eof[0]}, "frame end");
      end
   endtask

   task automatic step(input logic v, input logic [63:0] w, input string tag, output logic took);
      @(negedge clk);
      compare();
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
      in_valid  = v;
      in_word   = w;
      #1;
      stall_prev = out_valid && !out_ready;
      held = {out_pix, out_sor, out_eof};
      if (stall_prev) check("R7", {7'd0, in_ready}, 8'd0, "in_ready under stall");
      took = v && in_ready;
      if (out_valid && out_ready && q_pix.size() != 0) begin
         void'(q_pix.pop_front()); void'(q_sor.pop_front());
         void'(q_eof.pop_front()); void'(q_tag.pop_front());
      end
      if (took) begin
         q_pix.push_back(ref_group(w));
         q_sor.push_back(mcol == 0);
         q_eof.push_back(mcol == WPR-1 && mrow == TR-1);
         q_tag.push_back(tag);
         if (mcol == WPR-1) begin
            mcol = 0;
            mrow = (mrow == TR-1) ? 0 : mrow + 1;
         end else mcol++;
      end
   endtask

   task automatic send(input logic [63:0] w, input string tag);
      logic took;
      do step(1'b1, w, tag, took); while (!took);
   endtask

   initial begin
      logic took;
      repeat (3) @(negedge clk);
      check("R1", {6'd0, out_valid, in_ready}, 8'h01, "reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {6'd0, out_valid, in_ready}, 8'h01, "after reset");
      for (int i = 0; i < 8; i++) send('1, "R2");
      for (int i = 0; i < 8; i++) send('0, "R2");
      for (int b = 0; b < 64; b++) send(~(64'd1 << b), "R3");
      for (int i = 0; i < 16; i++) begin
         logic [63:0] w = '1;
         w[(i % 4) * 16 + 4 * (i % 4) + (i % 4)] = 1'b0;
         send(w, "R5");
      end
      bp = 1;
      for (int i = 0; i < 96; i++) begin
         logic [63:0] w = {$urandom, $urandom} | {$urandom, $urandom};
         if ((i % 3) == 0) w = w | {$urandom, $urandom};
         send(w, "R4");
         if ((i % 5) == 0) step(1'b0, '0, "R6", took);
      end
      bp = 0;
      repeat (4) step(1'b0, '0, "R6", took);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule